// File: doc/BRIEF.md
# Mailbox Control Flags and Interrupt Controller

This block keeps the control flags of a two-processor mailbox interface and turns them, together with the data-waiting signals of the mailbox channels, into the interrupt and reset outputs. The host changes the flags through a single control address. Each write byte carries a set/clear select in its top bit and a mask in the seven bits below it. Every flag whose mask bit is 1 takes the value of the select bit. Flags whose mask bit is 0 keep their value. Only the host may change the flags. The parasite processor can read them but cannot write them.

Two outputs reset other logic. The clear-all output purges the mailbox channels, and the parasite reset output holds the second processor in reset. Each one follows its own flag and is also forced on while the hardware reset is active. Two interrupt outputs are level conditions. Each combines an enable flag with a data-waiting input and drops as soon as the receiving side empties that latch. The block also builds the status byte that each side reads at the control address.

Top module: `mbx_ctrl_irq`

## Requirements
- R1: After a hardware reset, all seven flags are 0, so bits 5..0 of both status bytes read 0 and neither interrupt is asserted, whatever the channel inputs are.
- R2: While `rst` is 1, `par_rst_n` is 0 and `clear_all` is 1.
- R3: A host write to address 0 with bit 7 = 1 sets each flag whose mask bit is 1 and leaves the other flags unchanged. The byte is laid out, bit 7 down to bit 0, as select, T, P, V, M, J, I, Q. The change is visible just after the clock edge that takes the write, so writing 0x92 sets V and I.
- R4: A host write to address 0 with bit 7 = 0 clears each flag whose mask bit is 1 and leaves the others unchanged, so writing 0x12 clears V and I.
- R5: A host write to any address other than 0 leaves every flag unchanged.
- R6: A parasite write leaves every flag unchanged, including a parasite write to address 0.
- R7: Each status byte reads, bit 7 down to bit 0, the side's channel-1 data-available input, the side's channel-1 not-full input, then P, V, M, J, I and Q. T never appears in either status byte.
- R8: `host_irq_n` is 0 exactly when Q = 1 and `h_r4_avail` = 1.
- R9: `par_irq_n` is 0 exactly when (I = 1 and `p_r1_avail` = 1) or (J = 1 and `p_r4_avail` = 1).
- R10: The interrupts are levels. Each one releases in the same cycle its data-waiting input drops, while the enable flag stays set.
- R11: `clear_all` is 1 for as long as T = 1. Setting or clearing T leaves P, V, M, J, I and Q unchanged.
- R12: `par_rst_n` is 0 for as long as P = 1. Clearing P releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| par_we | input | 1 | Parasite write strobe |
| par_addr | input | 3 | Parasite register address |
| h_r1_avail | input | 1 | Channel 1 has data for the host |
| h_r1_room | input | 1 | Channel 1 host-side write path is not full |
| h_r4_avail | input | 1 | Channel 4 has data waiting for the host |
| p_r1_avail | input | 1 | Channel 1 has data waiting for the parasite |
| p_r1_room | input | 1 | Channel 1 parasite-side write path is not full |
| p_r4_avail | input | 1 | Channel 4 has data waiting for the parasite |
| host_status | output | 8 | Status byte seen by the host at address 0 |
| par_status | output | 8 | Status byte seen by the parasite at address 0 |
| host_irq_n | output | 1 | Active-low interrupt to the host |
| par_irq_n | output | 1 | Active-low maskable interrupt to the parasite |
| par_rst_n | output | 1 | Active-low reset to the parasite |
| clear_all | output | 1 | Purge pulse level for all channels |

## Verification
The bench checks the masked write in both polarities. A design that mixes up the select and mask bits would also change flags that were not addressed, and the 0x92 and 0x12 cases, together with random masks, would expose it. The bench also sends parasite writes and host writes to other addresses to address 0. A design that lets either one through would show changed flags in the status byte. It toggles the channel data-waiting inputs while the enable flags stay set, so an interrupt that latches instead of following its cause would stay asserted and be caught. It also sets and clears T among other flags to catch a design where the clear-all action wipes the other flags or where T leaks into the status byte.

// File: rtl/mbx_ctrl_pkg.sv
package mbx_ctrl_pkg;

    localparam int CTRL_W  = 8;
    localparam int FLAG_N  = 7;
    localparam int SEL_BIT = CTRL_W - 1;

    // Field order matches the control byte, bit 6 down to bit 0.
    typedef struct packed {
        logic t;
        logic p;
        logic v;
        logic m;
        logic j;
        logic i;
        logic q;
    } mbx_flags_t;

    typedef enum logic [1:0] {
        WSRC_NONE    = 2'd0,
        WSRC_HOST    = 2'd1,
        WSRC_PAR_DROP = 2'd2
    } mbx_wsrc_e;

    typedef struct packed {
        logic avail;
        logic room;
    } mbx_side_t;

    function automatic mbx_flags_t mbx_apply(input mbx_flags_t cur,
                                             input logic [CTRL_W-1:0] wbyte);
        logic [FLAG_N-1:0] mask;
        logic [FLAG_N-1:0] now;
        mask = wbyte[FLAG_N-1:0];
        now  = cur;
        if (wbyte[SEL_BIT])
            now = now | mask;
        else
            now = now & ~mask;
        return mbx_flags_t'(now);
    endfunction

    function automatic logic [CTRL_W-1:0] mbx_status(input mbx_flags_t f,
                                                     input mbx_side_t s);
        return {s.avail, s.room, f.p, f.v, f.m, f.j, f.i, f.q};
    endfunction

endpackage

// File: rtl/mbx_flag_reg.sv
module mbx_flag_reg
    import mbx_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CTRL_W-1:0] host_wdata,
    input  logic              par_we,
    input  logic [ADDR_W-1:0] par_addr,
    output mbx_flags_t        flags
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    mbx_wsrc_e  src;
    mbx_flags_t nxt;

    always_comb begin
        if (host_we && host_addr == CTRL_A)
            src = WSRC_HOST;
        else if (par_we && par_addr == CTRL_A)
            src = WSRC_PAR_DROP;
        else
            src = WSRC_NONE;
    end

    always_comb begin
        case (src)
            WSRC_HOST:     nxt = mbx_apply(flags, host_wdata);
            WSRC_PAR_DROP: nxt = flags;     // parasite has no write access
            default:       nxt = flags;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= nxt;
    end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen
    import mbx_ctrl_pkg::*;
(
    input  logic       rst,
    input  mbx_flags_t flags,
    input  logic       h_r4_avail,
    input  logic       p_r1_avail,
    input  logic       p_r4_avail,
    output logic       host_irq_n,
    output logic       par_irq_n,
    output logic       par_rst_n,
    output logic       clear_all
);
    logic host_cause;
    logic par_cause_r1;
    logic par_cause_r4;

    always_comb begin
        host_cause   = flags.q & h_r4_avail;
        par_cause_r1 = flags.i & p_r1_avail;
        par_cause_r4 = flags.j & p_r4_avail;
        host_irq_n   = ~host_cause;
        par_irq_n    = ~(par_cause_r1 | par_cause_r4);
        par_rst_n    = ~(rst | flags.p);
        clear_all    = rst | flags.t;
    end
endmodule

// File: rtl/mbx_status_fmt.sv
module mbx_status_fmt
    import mbx_ctrl_pkg::*;
#(
    parameter int SIDES = 2
) (
    input  mbx_flags_t              flags,
    input  mbx_side_t [SIDES-1:0]   side_in,
    output logic [SIDES-1:0][CTRL_W-1:0] side_status
);
    for (genvar g = 0; g < SIDES; g++) begin : g_side
        assign side_status[g] = mbx_status(flags, side_in[g]);
    end
endmodule

// File: rtl/mbx_ctrl_irq.sv
module mbx_ctrl_irq
    import mbx_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              par_we,
    input  logic [ADDR_W-1:0] par_addr,
    input  logic              h_r1_avail,
    input  logic              h_r1_room,
    input  logic              h_r4_avail,
    input  logic              p_r1_avail,
    input  logic              p_r1_room,
    input  logic              p_r4_avail,
    output logic [7:0]        host_status,
    output logic [7:0]        par_status,
    output logic              host_irq_n,
    output logic              par_irq_n,
    output logic              par_rst_n,
    output logic              clear_all
);
    localparam int SIDES  = 2;
    localparam int H_SIDE = 0;
    localparam int P_SIDE = 1;

    mbx_flags_t                      flags;
    mbx_side_t [SIDES-1:0]           side_in;
    logic [SIDES-1:0][CTRL_W-1:0]    side_status;

    mbx_flag_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_flags (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .par_we     (par_we),
        .par_addr   (par_addr),
        .flags      (flags)
    );

    mbx_irq_gen u_irq (
        .rst        (rst),
        .flags      (flags),
        .h_r4_avail (h_r4_avail),
        .p_r1_avail (p_r1_avail),
        .p_r4_avail (p_r4_avail),
        .host_irq_n (host_irq_n),
        .par_irq_n  (par_irq_n),
        .par_rst_n  (par_rst_n),
        .clear_all  (clear_all)
    );

    always_comb begin
        side_in[H_SIDE] = '{avail: h_r1_avail, room: h_r1_room};
        side_in[P_SIDE] = '{avail: p_r1_avail, room: p_r1_room};
    end

    mbx_status_fmt #(.SIDES(SIDES)) u_status (
        .flags       (flags),
        .side_in     (side_in),
        .side_status (side_status)
    );

    assign host_status = side_status[H_SIDE];
    assign par_status  = side_status[P_SIDE];
endmodule

// File: rtl/mbx_ctrl_irq_chk.sv
module mbx_ctrl_irq_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_wdata,
    input logic              par_we,
    input logic              h_r4_avail,
    input logic              p_r1_avail,
    input logic              p_r4_avail,
    input logic [7:0]        host_status,
    input logic [7:0]        par_status,
    input logic              host_irq_n,
    input logic              par_irq_n,
    input logic              par_rst_n,
    input logic              clear_all
);
    logic host_ctrl_wr;
    assign host_ctrl_wr = host_we && (host_addr == '0);

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (host_status[5:0] == 6'd0));

    // R2
    rst_outputs_chk: assert property (@(posedge clk)
        rst |-> (!par_rst_n && clear_all));

    // R3
    set_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (host_ctrl_wr && host_wdata[7]) |=>
            ((host_status[5:0] & $past(host_wdata[5:0])) == $past(host_wdata[5:0])));

    // R4
    clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (host_ctrl_wr && !host_wdata[7]) |=>
            ((host_status[5:0] & $past(host_wdata[5:0])) == 6'd0));

    // R6
    par_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (par_we && !host_ctrl_wr) |=> $stable(host_status[5:0]));

    // R7
    sides_agree_chk: assert property (@(posedge clk) disable iff (rst)
        host_status[5:0] == par_status[5:0]);

    // R8
    host_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_irq_n) == (host_status[0] && h_r4_avail));

    // R9
    par_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!par_irq_n) == ((par_status[1] && p_r1_avail) || (par_status[2] && p_r4_avail)));

    // R12
    par_rst_flag_chk: assert property (@(posedge clk) disable iff (rst)
        host_status[5] |-> !par_rst_n);
endmodule

bind mbx_ctrl_irq mbx_ctrl_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .par_we      (par_we),
    .h_r4_avail  (h_r4_avail),
    .p_r1_avail  (p_r1_avail),
    .p_r4_avail  (p_r4_avail),
    .host_status (host_status),
    .par_status  (par_status),
    .host_irq_n  (host_irq_n),
    .par_irq_n   (par_irq_n),
    .par_rst_n   (par_rst_n),
    .clear_all   (clear_all)
);

// File: tb/tb_mbx_ctrl_irq.sv
`timescale 1ns/1ps
module tb_mbx_ctrl_irq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       par_we = 1'b0;
    logic [2:0] par_addr = '0;
    logic       h_r1_avail = 1'b0, h_r1_room = 1'b0, h_r4_avail = 1'b0;
    logic       p_r1_avail = 1'b0, p_r1_room = 1'b0, p_r4_avail = 1'b0;
    logic [7:0] host_status, par_status;
    logic       host_irq_n, par_irq_n, par_rst_n, clear_all;

    int checks = 0;
    int errors = 0;
    logic [6:0] model = '0;   // bit 6..0 = T P V M J I Q
    logic       done = 1'b0;

    always #2 clk = ~clk;

    mbx_ctrl_irq dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .par_we(par_we), .par_addr(par_addr),
        .h_r1_avail(h_r1_avail), .h_r1_room(h_r1_room), .h_r4_avail(h_r4_avail),
        .p_r1_avail(p_r1_avail), .p_r1_room(p_r1_room), .p_r4_avail(p_r4_avail),
        .host_status(host_status), .par_status(par_status),
        .host_irq_n(host_irq_n), .par_irq_n(par_irq_n),
        .par_rst_n(par_rst_n), .clear_all(clear_all)
    );

    function automatic logic [6:0] next_model(logic [6:0] cur, logic r, logic we,
                                              logic [2:0] a, logic [7:0] d);
        if (r) return 7'd0;
        if (we && a == 3'd0) return d[7] ? (cur | d[6:0]) : (cur & ~d[6:0]);
        return cur;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " R7 host status"}, host_status, {h_r1_avail, h_r1_room, model[5:0]});
        chk({tag, " R7 par status"}, par_status, {p_r1_avail, p_r1_room, model[5:0]});
        chk({tag, " R8 host irq"}, {7'd0, host_irq_n}, {7'd0, !(model[0] && h_r4_avail)});
        chk({tag, " R9 par irq"}, {7'd0, par_irq_n},
            {7'd0, !((model[1] && p_r1_avail) || (model[2] && p_r4_avail))});
        chk({tag, " R12/R2 par rst"}, {7'd0, par_rst_n}, {7'd0, !(rst || model[5])});
        chk({tag, " R11/R2 clear all"}, {7'd0, clear_all}, {7'd0, rst || model[6]});
    endtask

    // one cycle: drive before the edge, update model at edge, sample 1 ns later
    task automatic step(string tag);
        @(posedge clk);
        model = next_model(model, rst, host_we, host_addr, host_wdata);
        #1;
        check_all(tag);
    endtask

    task automatic host_wr(logic [2:0] a, logic [7:0] d, string tag);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d; par_we = 1'b0;
        step(tag);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        h_r1_avail = 1; h_r4_avail = 1; p_r1_avail = 1; p_r4_avail = 1;
        step("R2 reset held");
        step("R2 reset held");
        @(negedge clk); rst = 1'b0;
        #1;
        check_all("R1 after reset");
        chk("R1 host status low bits", {2'b00, host_status[5:0]}, 8'h00);

        host_wr(3'd0, 8'hFF, "R3 set all");
        chk("R3 all flags set", {2'b00, host_status[5:0]}, 8'h3F);
        host_wr(3'd0, 8'h7F, "R4 clear all");
        chk("R4 all flags clear", {2'b00, host_status[5:0]}, 8'h00);
        host_wr(3'd0, 8'h92, "R3 set V and I");
        chk("R3 0x92 gives V,I", {2'b00, host_status[5:0]}, 8'h12);
        host_wr(3'd0, 8'h81, "R3 set Q");
        chk("R3 Q added, V,I kept", {2'b00, host_status[5:0]}, 8'h13);
        host_wr(3'd0, 8'h12, "R4 clear V and I");
        chk("R4 0x12 leaves Q", {2'b00, host_status[5:0]}, 8'h01);

        // R5 host write to another address
        host_wr(3'd3, 8'hFF, "R5 other address");
        chk("R5 flags unchanged", {2'b00, host_status[5:0]}, 8'h01);

        // R6 parasite write to address 0
        @(negedge clk); par_we = 1'b1; par_addr = 3'd0;
        step("R6 parasite write");
        @(negedge clk); par_we = 1'b0;
        chk("R6 flags unchanged", {2'b00, par_status[5:0]}, 8'h01);

        // R10 interrupt follows its cause
        host_wr(3'd0, 8'h86, "R10 enable I,J");
        @(negedge clk); p_r1_avail = 0; p_r4_avail = 0; h_r4_avail = 0; #1;
        chk("R10 par irq released", {7'd0, par_irq_n}, 8'h01);
        chk("R10 host irq released", {7'd0, host_irq_n}, 8'h01);
        p_r4_avail = 1; #1;
        chk("R10 par irq from ch4", {7'd0, par_irq_n}, 8'h00);

        // R11 T does not disturb other flags and is not readable
        host_wr(3'd0, 8'hC0, "R11 set T");
        chk("R11 clear_all active", {7'd0, clear_all}, 8'h01);
        chk("R11 flags kept, T hidden", {2'b00, host_status[5:0]}, 8'h07);
        host_wr(3'd0, 8'h40, "R11 clear T");
        chk("R11 clear_all released", {7'd0, clear_all}, 8'h00);

        // R12 P holds parasite reset
        host_wr(3'd0, 8'hA0, "R12 set P");
        chk("R12 par_rst_n low", {7'd0, par_rst_n}, 8'h00);
        host_wr(3'd0, 8'h20, "R12 clear P");
        chk("R12 par_rst_n high", {7'd0, par_rst_n}, 8'h01);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            rst        = ($urandom % 64) == 0;
            host_we    = $urandom % 2;
            host_addr  = ($urandom % 2) ? 3'd0 : 3'($urandom);
            host_wdata = 8'($urandom);
            par_we     = $urandom % 2;
            par_addr   = 3'($urandom);
            h_r1_avail = $urandom % 2; h_r1_room = $urandom % 2;
            h_r4_avail = $urandom % 2; p_r1_avail = $urandom % 2;
            p_r1_room  = $urandom % 2; p_r4_avail = $urandom % 2;
            step("random R3/R4/R5/R6");
        end
        @(negedge clk);
        rst = 1'b0; host_we = 1'b0; par_we = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule